// File: doc/BRIEF.md
# Six-Channel Ramped Digital Attenuator

This block scales the samples of a six-channel playback path by a per-channel attenuation. It sits after the sample interface and ahead of the output filters. Each setting is an 8-bit code in 0.5 dB steps. When a setting changes, the applied level does not jump to the new value. It walks toward the new target in 0.125 dB steps, at a pace picked by a rate select, so a level change makes no click.

The samples arrive as a time-multiplexed stream. Each valid beat carries one signed 24-bit sample and the index of its channel. Every channel keeps its own applied level and its own ramp pacing counter. One multiplier serves all channels, one beat at a time. The linear gain comes from a 48-entry table that covers one 6 dB span in eighth-dB steps, combined with one right shift per whole span. A global mute drives every channel to full attenuation through the same ramp, and only then zeroes the output. Releasing the mute lets each channel climb back to its programmed level.

Top module: `chan_attenuator`

## Requirements
- R1: After reset, out_valid and out_data are 0, and every channel starts at full attenuation (724 eighth-dB units).
- R2: A beat with in_valid=1 and in_chan<6 produces exactly one output beat, with the same channel index, two clock cycles later. A beat with in_chan 6 or 7 produces no output.
- R3: For applied attenuation a, with s=a/48 and r=a%48, the output is floor((x*g(r) + 2^(22+s)) / 2^(23+s)). Here x is the input and g(0)=2^23, g(k)=floor(g(k-1)*8268751/2^23). At a=0 the output equals the input.
- R4: The target of channel c, in eighth-dB units, is 4*code. Code c sits in att_codes bits [8c+7:8c]. Codes above 181 act as 181.
- R5: On a ramp tick of its channel, the applied level moves one unit toward the target. It stays put when it already equals the target. A beat is scaled with the level as it stood before that beat's own update.
- R6: Each channel has a 3-bit beat counter. The counter advances on every accepted beat of that channel and is 0 after reset. A beat ticks when (counter AND m)==m, with m=2^ramp_rate-1. So a tick comes every 1, 2, 4 or 8 beats for ramp_rate 0 to 3.
- R7: While mute=1, every channel's target is 724. A beat is output as 0 when mute=1 and its channel's level is 724.
- R8: After mute is released, each channel ramps from its current level back to its programmed target.
- R9: The level of a channel changes only on beats of that channel.
- R10: The magnitude of each output never exceeds the magnitude of its input sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat strobe |
| in_chan | input | 3 | Channel index of the input beat |
| in_data | input | 24 | Signed input sample |
| att_codes | input | 48 | Six 8-bit attenuation codes, 0.5 dB per step |
| ramp_rate | input | 2 | Ramp pace select |
| mute | input | 1 | Ramp all channels to full attenuation, then zero |
| out_valid | output | 1 | Output beat strobe |
| out_chan | output | 3 | Channel index of the output beat |
| out_data | output | 24 | Signed scaled sample |

## Verification
Every result is due two clock cycles after its beat: one register holds the level lookup and one holds the product. So the bench carries each expected value through a two-deep delay line and compares it at the falling edge that follows the second rising edge. Level changes show up only in the outputs of later beats of the same channel, because a beat is scaled with the level before its own update. The bench model therefore updates its per-channel state after it has computed the expected value for that beat. Its inputs, codes, rate and mute are all sampled at the same edge as the beat.

// File: rtl/vol_pkg.sv
package vol_pkg;
  // Fraction bits of the linear gain (unity = 2**GAIN_FRAC).
  localparam int GAIN_FRAC = 23;
  // round(2**23 * 10**(-0.125/20)): one eighth-dB step.
  localparam longint STEP_MULT = 64'sd8268751;

  // Linear gain for idx eighth-dB steps within one 6 dB span.
  function automatic longint eighth_db_gain(input int idx);
    longint g;
    g = 64'sd1 <<< GAIN_FRAC;
    for (int k = 0; k < idx; k++) g = (g * STEP_MULT) >>> GAIN_FRAC;
    return g;
  endfunction
endpackage

// File: rtl/vol_ramp.sv
module vol_ramp #(
  parameter int NCH = 6,
  parameter int CW = 8,
  parameter int MAX_CODE = 181,
  parameter int UNITS = 4,
  parameter int RATE_W = 2,
  localparam int CHW = $clog2(NCH),
  localparam int ATT_MAX = MAX_CODE * UNITS,
  localparam int AW = $clog2(ATT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic [CHW-1:0]    chan,
  input  logic [NCH*CW-1:0] codes,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              mute,
  output logic [AW-1:0]     att_now,
  output logic              zero_now
);
  localparam int CNTW = (1 << RATE_W) - 1;

  logic [NCH*AW-1:0] cur_flat;
  logic [CNTW-1:0]   mask;

  assign mask = CNTW'((1 << rate_sel) - 1);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CW-1:0]   code;
    logic [AW-1:0]   tgt;
    logic [AW-1:0]   cur_q;
    logic [CNTW-1:0] cnt_q;
    logic            hit;
    logic            tick;

    assign code = codes[c*CW +: CW];
    assign hit  = acc && (chan == CHW'(c));
    assign tick = hit && ((cnt_q & mask) == mask);

    always_comb begin
      if (mute || code > CW'(MAX_CODE)) tgt = AW'(ATT_MAX);
      else                             tgt = AW'(code) * AW'(UNITS);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cur_q <= AW'(ATT_MAX);
        cnt_q <= '0;
      end else if (hit) begin
        cnt_q <= cnt_q + 1'b1;
        if (tick) begin
          if (cur_q < tgt)      cur_q <= cur_q + 1'b1;
          else if (cur_q > tgt) cur_q <= cur_q - 1'b1;
        end
      end
    end

    assign cur_flat[c*AW +: AW] = cur_q;
  end

  always_comb begin
    att_now = '0;
    for (int c = 0; c < NCH; c++)
      if (chan == CHW'(c)) att_now = cur_flat[c*AW +: AW];
  end

  assign zero_now = mute && (att_now == AW'(ATT_MAX));
endmodule

// File: rtl/vol_lookup.sv
module vol_lookup #(
  parameter int DW = 24,
  parameter int CHW = 3,
  parameter int AW = 10,
  parameter int SPAN = 48,
  parameter int GW = 24,
  parameter int SHW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc,
  input  logic [CHW-1:0]       chan,
  input  logic signed [DW-1:0] data,
  input  logic [AW-1:0]        att,
  input  logic                 zero,
  output logic                 s_valid,
  output logic [CHW-1:0]       s_chan,
  output logic signed [DW-1:0] s_data,
  output logic [GW-1:0]        s_mant,
  output logic [SHW-1:0]       s_shift,
  output logic                 s_zero
);
  localparam int RW = $clog2(SPAN);

  logic [GW-1:0]  rom [SPAN];
  logic [SHW-1:0] sh;
  logic [RW-1:0]  idx;

  for (genvar i = 0; i < SPAN; i++) begin : g_rom
    localparam logic [GW-1:0] ENTRY = GW'(vol_pkg::eighth_db_gain(i));
    assign rom[i] = ENTRY;
  end

  assign sh  = SHW'(att / AW'(SPAN));
  assign idx = RW'(att % AW'(SPAN));

  always_ff @(posedge clk) begin
    if (rst) s_valid <= 1'b0;
    else     s_valid <= acc;
    if (acc) begin
      s_chan  <= chan;
      s_data  <= data;
      s_mant  <= rom[idx];
      s_shift <= sh;
      s_zero  <= zero;
    end
  end
endmodule

// File: rtl/vol_scale.sv
module vol_scale #(
  parameter int DW = 24,
  parameter int CHW = 3,
  parameter int GW = 24,
  parameter int SHW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 s_valid,
  input  logic [CHW-1:0]       s_chan,
  input  logic signed [DW-1:0] s_data,
  input  logic [GW-1:0]        s_mant,
  input  logic [SHW-1:0]       s_shift,
  input  logic                 s_zero,
  output logic                 o_valid,
  output logic [CHW-1:0]       o_chan,
  output logic signed [DW-1:0] o_data
);
  localparam int PW = DW + GW + 1;
  localparam int GF = vol_pkg::GAIN_FRAC;
  localparam logic signed [PW-1:0] HI = PW'((64'sd1 <<< (DW - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] LO = -HI - PW'(1);

  logic signed [PW-1:0] prod, half, rnd, shf;
  logic signed [DW-1:0] sat;

  always_comb begin
    prod = PW'(s_data) * PW'($signed({1'b0, s_mant}));
    half = PW'(1) <<< (GF - 1 + int'(s_shift));
    rnd  = prod + half;
    shf  = rnd >>> (GF + int'(s_shift));
    if (shf > HI)      sat = DW'(HI);
    else if (shf < LO) sat = DW'(LO);
    else               sat = DW'(shf);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_chan  <= '0;
      o_data  <= '0;
    end else begin
      o_valid <= s_valid;
      if (s_valid) begin
        o_chan <= s_chan;
        o_data <= s_zero ? '0 : sat;
      end
    end
  end
endmodule

// File: rtl/chan_attenuator.sv
module chan_attenuator #(
  parameter int NCH = 6,
  parameter int DW = 24,
  parameter int CW = 8,
  parameter int MAX_CODE = 181,
  parameter int UNITS = 4,
  parameter int SPAN = 48,
  parameter int RATE_W = 2,
  localparam int CHW = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [CHW-1:0]       in_chan,
  input  logic signed [DW-1:0] in_data,
  input  logic [NCH*CW-1:0]    att_codes,
  input  logic [RATE_W-1:0]    ramp_rate,
  input  logic                 mute,
  output logic                 out_valid,
  output logic [CHW-1:0]       out_chan,
  output logic signed [DW-1:0] out_data
);
  localparam int ATT_MAX = MAX_CODE * UNITS;
  localparam int AW = $clog2(ATT_MAX + 1);
  localparam int GW = vol_pkg::GAIN_FRAC + 1;
  localparam int SHW = $clog2(ATT_MAX / SPAN + 1);

  logic                 acc;
  logic [AW-1:0]        att_now;
  logic                 zero_now;
  logic                 s_valid, s_zero;
  logic [CHW-1:0]       s_chan;
  logic signed [DW-1:0] s_data;
  logic [GW-1:0]        s_mant;
  logic [SHW-1:0]       s_shift;

  assign acc = in_valid && (in_chan < CHW'(NCH));

  vol_ramp #(.NCH(NCH), .CW(CW), .MAX_CODE(MAX_CODE), .UNITS(UNITS), .RATE_W(RATE_W)) u_ramp (
    .clk(clk), .rst(rst), .acc(acc), .chan(in_chan), .codes(att_codes),
    .rate_sel(ramp_rate), .mute(mute), .att_now(att_now), .zero_now(zero_now));

  vol_lookup #(.DW(DW), .CHW(CHW), .AW(AW), .SPAN(SPAN), .GW(GW), .SHW(SHW)) u_lookup (
    .clk(clk), .rst(rst), .acc(acc), .chan(in_chan), .data(in_data), .att(att_now),
    .zero(zero_now), .s_valid(s_valid), .s_chan(s_chan), .s_data(s_data),
    .s_mant(s_mant), .s_shift(s_shift), .s_zero(s_zero));

  vol_scale #(.DW(DW), .CHW(CHW), .GW(GW), .SHW(SHW)) u_scale (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_chan(s_chan), .s_data(s_data),
    .s_mant(s_mant), .s_shift(s_shift), .s_zero(s_zero),
    .o_valid(out_valid), .o_chan(out_chan), .o_data(out_data));
endmodule

// File: rtl/chan_attenuator_chk.sv
module chan_attenuator_chk #(
  parameter int NCH = 6,
  parameter int DW = 24,
  parameter int CHW = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [CHW-1:0]       in_chan,
  input logic signed [DW-1:0] in_data,
  input logic                 out_valid,
  input logic [CHW-1:0]       out_chan,
  input logic signed [DW-1:0] out_data
);
  logic [1:0] since;
  logic       acc;

  assign acc = in_valid && (in_chan < CHW'(NCH));

  always_ff @(posedge clk) begin
    if (rst)              since <= '0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  function automatic logic [DW:0] mag(input logic signed [DW-1:0] v);
    return v[DW-1] ? (DW+1)'(-(DW+1)'(v)) : (DW+1)'(v);
  endfunction

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid);

  a_r2_one_out_per_beat: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2) |-> (out_valid == $past(acc, 2)));

  a_r2_chan_kept: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2 && out_valid) |-> (out_chan == $past(in_chan, 2)));

  a_r10_no_growth: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2 && out_valid) |-> (mag(out_data) <= mag($past(in_data, 2))));
endmodule

bind chan_attenuator chan_attenuator_chk #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan), .in_data(in_data),
  .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data));

// File: tb/chan_attenuator_tb.sv
`timescale 1ns/1ps
module chan_attenuator_tb;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic [2:0]         in_chan = '0;
  logic signed [23:0] in_data = '0;
  logic [47:0]        att_codes = '0;
  logic [1:0]         ramp_rate = '0;
  logic               mute = 1'b0;
  logic               out_valid;
  logic [2:0]         out_chan;
  logic signed [23:0] out_data;

  chan_attenuator u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan), .in_data(in_data),
    .att_codes(att_codes), .ramp_rate(ramp_rate), .mute(mute),
    .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int b_code [6];
  int b_rate = 0;
  bit b_mute = 1'b0;
  int mcur [6];
  int mcnt [6];
  bit d1_v = 0, d2_v = 0;
  int d1_ch, d2_ch, d1_exp, d2_exp, d1_in, d2_in;
  string d1_tag, d2_tag, phase;

  function automatic int exp_out(int din, int att);
    longint g, p;
    int s, r;
    s = att / 48;
    r = att % 48;
    g = 64'sd1 <<< 23;
    for (int k = 0; k < r; k++) g = (g * 64'sd8268751) >>> 23;
    p = longint'(din) * g;
    p = p + (64'sd1 <<< (22 + s));
    p = p >>> (23 + s);
    return int'(p);
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(bit ok, string tag, string what, int got, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic cycle(input bit v, input int ch, input int din);
    int tgt, mask;
    @(negedge clk);
    if (d2_v) begin
      chk(out_valid === 1'b1 && int'(out_chan) == d2_ch, "R2", "beat presence/channel",
          int'({out_valid, out_chan}), 8 + d2_ch);
      chk(int'(out_data) == d2_exp, d2_tag, "sample", int'(out_data), d2_exp);
      chk(iabs(int'(out_data)) <= iabs(d2_in), "R10", "magnitude", iabs(int'(out_data)), iabs(d2_in));
    end else begin
      chk(out_valid === 1'b0, "R2", "no beat expected", int'(out_valid), 0);
    end
    d2_v = d1_v; d2_ch = d1_ch; d2_exp = d1_exp; d2_in = d1_in; d2_tag = d1_tag;
    in_valid = v;
    in_chan = 3'(ch);
    in_data = 24'(din);
    for (int c = 0; c < 6; c++) att_codes[c*8 +: 8] = 8'(b_code[c]);
    ramp_rate = 2'(b_rate);
    mute = b_mute;
    d1_v = v && ch < 6;
    d1_ch = ch; d1_in = din; d1_tag = phase;
    if (d1_v) begin
      d1_exp = (b_mute && mcur[ch] == 724) ? 0 : exp_out(din, mcur[ch]);
      tgt = b_mute ? 724 : 4 * ((b_code[ch] > 181) ? 181 : b_code[ch]);
      mask = (1 << b_rate) - 1;
      if ((mcnt[ch] & mask) == mask) begin
        if (mcur[ch] < tgt) mcur[ch]++;
        else if (mcur[ch] > tgt) mcur[ch]--;
      end
      mcnt[ch] = (mcnt[ch] + 1) & 7;
    end
  endtask

  function automatic int rnd24();
    return int'($urandom) >>> 8;
  endfunction

  task automatic frames(int n);
    for (int f = 0; f < n; f++)
      for (int c = 0; c < 6; c++) cycle(1'b1, c, rnd24());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hA77E));
    for (int c = 0; c < 6; c++) begin b_code[c] = 0; mcur[c] = 724; mcnt[c] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0 && out_data === 24'sd0, "R1", "reset outputs", int'(out_data), 0);

    // R1: first beats use full attenuation
    phase = "R1";
    for (int c = 0; c < 6; c++) cycle(1'b1, c, 24'sh400000 - c);
    // R5: ramp every channel down to 0 dB one unit per beat
    phase = "R5";
    frames(730);
    // R3: unity gain corners
    phase = "R3";
    cycle(1'b1, 0, 8388607);
    cycle(1'b1, 1, -8388608);
    cycle(1'b1, 2, 1);
    cycle(1'b1, 3, -1);
    cycle(1'b1, 4, 0);
    // R4: clamp of codes above 181, plus a mid code
    phase = "R4";
    b_code[0] = 255; b_code[1] = 181; b_code[2] = 182; b_code[3] = 37;
    frames(730);
    // R6: slow paces
    phase = "R6";
    b_code[4] = 20; b_rate = 2;
    frames(60);
    b_rate = 3; b_code[5] = 9;
    frames(60);
    b_rate = 1; b_code[0] = 0;
    frames(40);
    // R2: out-of-range channel and gaps
    phase = "R2";
    cycle(1'b1, 6, 12345);
    cycle(1'b0, 0, 0);
    cycle(1'b1, 7, -12345);
    cycle(1'b1, 0, 777);
    // R9: random traffic, independent channels
    phase = "R9";
    for (int i = 0; i < 3000; i++) begin
      if (i % 250 == 0) begin
        b_rate = int'($urandom % 4);
        for (int c = 0; c < 6; c++) b_code[c] = int'($urandom % 256);
      end
      cycle(($urandom % 4) != 0, int'($urandom % 8), rnd24());
    end
    // R7: mute ramps down then zeroes
    phase = "R7";
    b_rate = 0; b_mute = 1'b1;
    frames(730);
    // R8: release ramps back up
    phase = "R8";
    b_mute = 1'b0;
    for (int c = 0; c < 6; c++) b_code[c] = 4 * c;
    frames(120);
    for (int i = 0; i < 3; i++) cycle(1'b0, 0, 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule